// File: doc/BRIEF.md
# Bit Field Pack Unit

A registered execution lane for a 64-bit datapath. It computes bit-field operations that merge or edit the fields of two operands. There are five half, byte and word packing forms, four single-bit edits that take a bit index from the second operand, two shifts that fill the vacated positions with ones, and two 32-bit rotates whose result is sign-extended to the full width.

An issuing stage presents both operands, a 4-bit operation code and a valid strobe in the same cycle. One clock edge later the result and its valid flag appear on the registered outputs. A new operation may be issued every cycle. When no valid operation is presented, the output register keeps its last value.

Top module: `bfp_unit`

## Requirements
- R1: Synchronous active-high reset clears `out_valid` and `result` to zero on the next edge, even when `in_valid` is high in that same cycle.
- R2: `out_valid` equals `in_valid` from one cycle earlier. `result` changes only on an edge where `in_valid` was high and holds otherwise.
- R3: Operation codes 0, 1 and 2 select the half and byte packing forms:
  - Code 0 gives {B[31:0], A[31:0]}.
  - Code 1 gives {B[63:32], A[63:32]}.
  - Code 2 gives B[7:0] in bits 15:8, A[7:0] in bits 7:0, and zero in all higher bits.
- R4: Operation codes 3 and 4 build a 32-bit word, then sign-extend it from bit 31:
  - Code 3 builds {B[15:0], A[15:0]}.
  - Code 4 builds {B[15:0], A[31:16]}.
- R5: Operation codes 5, 6 and 7 edit the single bit of A selected by the index. The index is B[5:0].
  - Code 5 sets that bit.
  - Code 6 clears that bit.
  - Code 7 inverts that bit.
  - All other bits of A pass through unchanged.
- R6: Operation code 8 returns bit A[index] in result bit 0. Result bits 63:1 are zero.
- R7: Bits 63:6 of B have no effect on the outcome of codes 5 to 10.
- R8: Code 9 shifts A left by B[5:0] and fills the vacated low bits with ones. Code 10 shifts A right by B[5:0] and fills the vacated high bits with ones.
- R9: Codes 11 and 12 rotate A[31:0] by B[4:0], left for code 11 and right for code 12. The 32-bit result is then sign-extended to 64 bits.
- R10: Operation codes 13, 14 and 15 produce an all-zero result, still with a valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B (second field source, index or amount) |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Reset and an issued operation can land on the same edge. The bench raises `rst` and `in_valid` together, with a pack operation on non-zero operands, and requires the next sample to show a zero result and no valid flag. The second collision is the end of a back-to-back stream: the issue strobe drops while new operand values appear on the inputs. One cycle later the output must still carry the previous result, and `out_valid` must be low.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [3:0] {
    OP_PACK   = 4'd0,
    OP_PACKU  = 4'd1,
    OP_PACKH  = 4'd2,
    OP_PACKW  = 4'd3,
    OP_PACKUW = 4'd4,
    OP_BSET   = 4'd5,
    OP_BCLR   = 4'd6,
    OP_BINV   = 4'd7,
    OP_BEXT   = 4'd8,
    OP_SLO    = 4'd9,
    OP_SRO    = 4'd10,
    OP_ROLW   = 4'd11,
    OP_RORW   = 4'd12
  } bfp_op_e;
endpackage

// File: rtl/bfp_pack_lane.sv
module bfp_pack_lane
  import bfp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int HALF = XLEN / 2;
  localparam int QTR  = WORD / 2;

  bfp_op_e        op_e;
  logic [WORD-1:0] wrd;

  assign op_e = bfp_op_e'(op);

  always_comb begin
    res = '0;
    wrd = '0;
    case (op_e)
      OP_PACK:   res = {b[HALF-1:0], a[HALF-1:0]};
      OP_PACKU:  res = {b[XLEN-1:HALF], a[XLEN-1:HALF]};
      OP_PACKH:  res = {{(XLEN-16){1'b0}}, b[7:0], a[7:0]};
      OP_PACKW: begin
        wrd = {b[QTR-1:0], a[QTR-1:0]};
        res = {{(XLEN-WORD){wrd[WORD-1]}}, wrd};
      end
      OP_PACKUW: begin
        wrd = {b[QTR-1:0], a[WORD-1:QTR]};
        res = {{(XLEN-WORD){wrd[WORD-1]}}, wrd};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bfp_bit_edit.sv
module bfp_bit_edit
  import bfp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IDXW = $clog2(XLEN)
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] res
);
  bfp_op_e         op_e;
  logic [XLEN-1:0] onehot;

  assign op_e = bfp_op_e'(op);

  for (genvar g = 0; g < XLEN; g++) begin : g_dec
    assign onehot[g] = (idx == IDXW'(g));
  end

  always_comb begin
    case (op_e)
      OP_BSET: res = a | onehot;
      OP_BCLR: res = a & ~onehot;
      OP_BINV: res = a ^ onehot;
      OP_BEXT: res = {{(XLEN-1){1'b0}}, |(a & onehot)};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bfp_shift_fill.sv
module bfp_shift_fill
  import bfp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32,
  parameter int IDXW = $clog2(XLEN),
  parameter int ROTW = $clog2(WORD)
) (
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [IDXW-1:0] amt,
  output logic [XLEN-1:0] res
);
  bfp_op_e         op_e;
  logic [WORD-1:0] w;
  logic [ROTW-1:0] r;
  logic [WORD-1:0] rot;

  assign op_e = bfp_op_e'(op);
  assign w    = a[WORD-1:0];
  assign r    = amt[ROTW-1:0];

  always_comb begin
    res = '0;
    rot = '0;
    case (op_e)
      OP_SLO: res = ~((~a) << amt);
      OP_SRO: res = ~((~a) >> amt);
      OP_ROLW: begin
        rot = (w << r) | (w >> (WORD - int'(r)));
        res = {{(XLEN-WORD){rot[WORD-1]}}, rot};
      end
      OP_RORW: begin
        rot = (w >> r) | (w << (WORD - int'(r)));
        res = {{(XLEN-WORD){rot[WORD-1]}}, rot};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/bfp_unit.sv
module bfp_unit #(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);
  localparam int IDXW = $clog2(XLEN);

  logic [XLEN-1:0] pack_res, bit_res, shf_res, next_res;

  bfp_pack_lane #(.XLEN(XLEN), .WORD(WORD)) u_pack (
    .op(op), .a(opa), .b(opb), .res(pack_res)
  );

  bfp_bit_edit #(.XLEN(XLEN), .IDXW(IDXW)) u_bit (
    .op(op), .a(opa), .idx(opb[IDXW-1:0]), .res(bit_res)
  );

  bfp_shift_fill #(.XLEN(XLEN), .WORD(WORD), .IDXW(IDXW)) u_shf (
    .op(op), .a(opa), .amt(opb[IDXW-1:0]), .res(shf_res)
  );

  // Each lane drives zero for codes it does not own, so an OR merges them.
  assign next_res = pack_res | bit_res | shf_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/bfp_unit_chk.sv
module bfp_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [3:0]      op,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  a_r4_word_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd3 || op == 4'd4)) |=>
      (result[XLEN-1:31] == '0 || result[XLEN-1:31] == '1));

  a_r6_extract_one_bit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd8) |=> (result[XLEN-1:1] == '0));

  a_r9_rotate_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == 4'd11 || op == 4'd12)) |=>
      (result[XLEN-1:31] == '0 || result[XLEN-1:31] == '1));

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd13) |=> (result == '0));
endmodule

bind bfp_unit bfp_unit_chk #(.XLEN(XLEN)) u_bfp_unit_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .result(result)
);

// File: tb/bfp_unit_bench.sv
`timescale 1ns/1ps
module bfp_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bfp_unit u_bfp_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'd2) return "R3";
    if (c <= 4'd4) return "R4";
    if (c <= 4'd7) return "R5 R7";
    if (c == 4'd8) return "R6 R7";
    if (c <= 4'd10) return "R8 R7";
    if (c <= 4'd12) return "R9";
    return "R10";
  endfunction

  function automatic logic [63:0] model(input logic [3:0] c, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    logic [31:0] w;
    logic [63:0] dd;
    int s;
    int k;
    s = int'(b[5:0]);
    k = int'(b[4:0]);
    r = '0;
    case (c)
      4'd0: r = {b[31:0], a[31:0]};
      4'd1: r = {b[63:32], a[63:32]};
      4'd2: r = {48'd0, b[7:0], a[7:0]};
      4'd3: begin w = {b[15:0], a[15:0]};  r = {{32{w[31]}}, w}; end
      4'd4: begin w = {b[15:0], a[31:16]}; r = {{32{w[31]}}, w}; end
      4'd5, 4'd6, 4'd7: begin
        r = a;
        if (c == 4'd5) r[s] = 1'b1;
        else if (c == 4'd6) r[s] = 1'b0;
        else r[s] = ~a[s];
      end
      4'd8: r = {63'd0, a[s]};
      4'd9:  for (int i = 0; i < 64; i++) r[i] = (i < s) ? 1'b1 : a[i - s];
      4'd10: for (int i = 0; i < 64; i++) r[i] = (i + s > 63) ? 1'b1 : a[i + s];
      4'd11: begin
        dd = {a[31:0], a[31:0]} << k;
        w = dd[63:32];
        r = {{32{w[31]}}, w};
      end
      4'd12: begin
        dd = {a[31:0], a[31:0]} >> k;
        w = dd[31:0];
        r = {{32{w[31]}}, w};
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Called at a negedge; leaves the bench at the following negedge.
  task automatic run_op(input logic [3:0] c, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] e;
    e = model(c, a, b);
    in_valid = 1'b1; op = c; opa = a; opb = b;
    @(negedge clk);
    chk(req_of(c), result, e);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pats [5];
    logic [63:0] held;
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF;
    pats[3] = 64'hF0E1_D2C3_B4A5_9687;
    pats[4] = 64'h8000_0000_7FFF_FFFF;

    repeat (3) @(negedge clk);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;

    // R3..R9 sweeps: every index/amount, random upper bits in B (R7)
    for (int c = 0; c <= 12; c++) begin
      for (int p = 0; p < 5; p++) begin
        for (int i = 0; i < 64; i++) begin
          logic [63:0] b;
          b = {$urandom, $urandom};
          b[5:0] = 6'(i);
          run_op(4'(c), pats[p], b);
        end
      end
    end

    // R10 undefined codes
    for (int c = 13; c <= 15; c++) begin
      run_op(4'(c), pats[3], pats[2]);
    end

    // R2 hold: issue stops while operands change
    run_op(4'd0, pats[2], pats[3]);
    held = model(4'd0, pats[2], pats[3]);
    in_valid = 1'b0; op = 4'd7; opa = pats[4]; opb = pats[1];
    @(negedge clk);
    chk("R2 hold result", result, held);
    chk("R2 idle valid", {63'd0, out_valid}, 64'd0);

    // R1 reset and issue in the same cycle
    in_valid = 1'b1; op = 4'd0; opa = pats[2]; opb = pats[3]; rst = 1'b1;
    @(negedge clk);
    chk("R1 reset beats issue result", result, 64'd0);
    chk("R1 reset beats issue valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule